// File: doc/BRIEF.md
# I2C interrupt status and clear registers

This block keeps the interrupt and status flags of an I2C peripheral and the write-1-to-clear register that goes with them. Three flags follow the data path: transmit-empty, transmit-interrupt and receive-not-empty. They move with strobes from the bus engine and with software accesses to the transmit and receive data registers. Nine event and error flags (address match, NACK, stop, bus error, arbitration lost, overrun/underrun, PEC error, timeout, alert) are set by engine strobes. Software clears them by writing ones to the clear register.

Software reaches the block over a simple register bus with no wait states. The read data is combinational from the address. A control register holds the interrupt enables, the no-clock-stretch mode bit and the transmit DMA enable. A peripheral enable input forces the data-path flags to their idle values. The parameter `SMBUS_EN` removes the three SMBus flags and their clear bits. Serial timing, shifters and DMA logic live elsewhere.

Register offsets: control 0x00, status 0x18, clear 0x1C, receive data 0x24, transmit data 0x28. Control bits: 0 transmit IE, 1 receive IE, 2 address IE, 3 NACK IE, 4 stop IE, 5 error IE, 6 no-stretch, 7 transmit DMA enable. Status bits: 0 TX empty, 1 TX interrupt, 2 RX not empty, 3 address match, 4 NACK, 5 stop, 8 bus error, 9 arbitration lost, 10 overrun/underrun, 11 PEC error, 12 timeout, 13 alert. Each clear-register bit clears the status bit at the same position.

Top module: `i2c_irq_regs`

## Requirements
- R1: After reset the status register reads 0x0001 (only TX empty set), the control register reads 0 and `irq` is 0.
- R2: A `ev_rx_byte` strobe sets status bit 2 on the next edge. A read of offset 0x24 clears it.
- R3: A `ev_tx_need` strobe sets status bits 0 and 1 on the next edge. A write to offset 0x28 clears both.
- R4: Writing 1 to status bit 0 (offset 0x18) flushes the transmit register, which leaves bit 0 set and bit 1 unchanged.
- R5: Writing 1 to status bit 1 sets the TX interrupt flag only when control bit 6 (no-stretch) is 1. Otherwise the write is ignored.
- R6: While `per_en` is 0, status bits 1 and 2 are 0 and bit 0 is 1 from the next edge on, whatever strobes arrive.
- R7: Each event strobe sets its status bit. Writing 1 to the same bit position at offset 0x1C clears it. Writing 0 there has no effect.
- R8: When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: Reading offset 0x1C always returns 0.
- R10: With `SMBUS_EN`=0, status bits 11, 12 and 13 stay 0 even when their strobes fire.
- R11: `irq` is the registered OR of the status flags ANDed with their enables. Error IE covers bits 8..13 and TX empty has no enable. It follows the flags one cycle later.
- R12: `tx_dma_req` is 1 exactly while the TX interrupt flag and control bit 7 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_en | input | 1 | Peripheral enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ev_rx_byte | input | 1 | Received byte moved into receive register |
| ev_tx_need | input | 1 | Transmit register emptied, next byte needed |
| ev_addr | input | 1 | Address match |
| ev_nack | input | 1 | NACK received |
| ev_stop | input | 1 | Stop detected |
| ev_berr | input | 1 | Bus error |
| ev_arlo | input | 1 | Arbitration lost |
| ev_ovr | input | 1 | Overrun/underrun |
| ev_pecerr | input | 1 | PEC error |
| ev_timeout | input | 1 | Timeout |
| ev_alert | input | 1 | Alert |
| irq | output | 1 | Registered interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
Every flag sits in one register that the status read shows directly. A wrong flag state is therefore visible on `bus_rdata` one edge after the offending strobe or access. The same state reaches `irq` one edge after that when its enable is set. A lost set in a set/clear collision, or a flush that disturbs the TX interrupt flag, shows as one wrong status bit. The no-stretch guard and the disable override are checked by reading status straight after the write or disable cycle. The second build with SMBus removed is read under the same strobes, so a leaking SMBus flag shows in bits 13:11.

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs #(
  parameter int AW       = 8,
  parameter bit SMBUS_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          per_en,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          ev_rx_byte,
  input  logic          ev_tx_need,
  input  logic          ev_addr,
  input  logic          ev_nack,
  input  logic          ev_stop,
  input  logic          ev_berr,
  input  logic          ev_arlo,
  input  logic          ev_ovr,
  input  logic          ev_pecerr,
  input  logic          ev_timeout,
  input  logic          ev_alert,
  output logic          irq,
  output logic          tx_dma_req
);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] OFS_STAT = AW'(8'h18);
  localparam logic [AW-1:0] OFS_CLR  = AW'(8'h1C);
  localparam logic [AW-1:0] OFS_RXD  = AW'(8'h24);
  localparam logic [AW-1:0] OFS_TXD  = AW'(8'h28);
  localparam logic [13:0]   SMB_BITS = 14'h3800;
  localparam logic [13:0]   EV_MASK  = SMBUS_EN ? 14'h3F38 : (14'h3F38 & ~SMB_BITS);

  logic [7:0]  ctrl;
  logic [13:0] flg, flg_nxt, ev_set, ev_clr, ien;
  logic        irq_q;

  wire wr_ctrl = bus_wr && bus_addr == OFS_CTRL;
  wire wr_stat = bus_wr && bus_addr == OFS_STAT;
  wire wr_clr  = bus_wr && bus_addr == OFS_CLR;
  wire wr_txd  = bus_wr && bus_addr == OFS_TXD;
  wire rd_rxd  = bus_rd && bus_addr == OFS_RXD;
  wire nostr   = ctrl[6];

  assign ev_set = {ev_alert, ev_timeout, ev_pecerr, ev_ovr, ev_arlo, ev_berr,
                   2'b00, ev_stop, ev_nack, ev_addr, 3'b000};
  assign ev_clr = wr_clr ? bus_wdata[13:0] : 14'h0;
  assign ien    = {{6{ctrl[5]}}, 2'b00, ctrl[4], ctrl[3], ctrl[2], ctrl[1], ctrl[0], 1'b0};

  always_comb begin
    flg_nxt = ((flg & ~ev_clr) | ev_set) & EV_MASK;
    if (!per_en) begin
      flg_nxt[0] = 1'b1;
      flg_nxt[1] = 1'b0;
      flg_nxt[2] = 1'b0;
    end else begin
      flg_nxt[0] = ev_tx_need || (wr_stat && bus_wdata[0]) || (flg[0] && !wr_txd);
      flg_nxt[1] = ev_tx_need || (wr_stat && bus_wdata[1] && nostr) || (flg[1] && !wr_txd);
      flg_nxt[2] = ev_rx_byte || (flg[2] && !rd_rxd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg   <= 14'h0001;
      ctrl  <= 8'h00;
      irq_q <= 1'b0;
    end else begin
      flg   <= flg_nxt;
      irq_q <= |(flg & ien);
      if (wr_ctrl) ctrl <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_addr == OFS_CTRL)      bus_rdata = {24'h0, ctrl};
    else if (bus_addr == OFS_STAT) bus_rdata = {18'h0, flg};
  end

  assign irq        = irq_q;
  assign tx_dma_req = flg[1] && ctrl[7];

  assert_disable_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !per_en |=> (flg[0] && !flg[1] && !flg[2]));
  assert_rx_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !ev_rx_byte) |=> !flg[2]);
  assert_tx_need_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_need && per_en) |=> (flg[0] && flg[1]));
  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr |=> flg[3]);
  assert_txis_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flg[1] && !ev_tx_need && !nostr) |=> !flg[1]);
  always_comb if (!SMBUS_EN) assert_no_smbus_R10: assert ((flg & SMB_BITS) == 14'h0);
endmodule

// File: tb/i2c_irq_regs_tb_top.sv
module i2c_irq_regs_tb_top;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0, rst_n = 1'b0, per_en = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [10:0] ev = 11'h0;
  logic [31:0] rdata, rdata_ns;
  logic        irq, irq_ns, dma, dma_ns;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2c_irq_regs #(.AW(8), .SMBUS_EN(1'b1)) dut_i (
    .clk, .rst_n, .per_en, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
    .bus_rdata(rdata), .ev_rx_byte(ev[0]), .ev_tx_need(ev[1]), .ev_addr(ev[2]),
    .ev_nack(ev[3]), .ev_stop(ev[4]), .ev_berr(ev[5]), .ev_arlo(ev[6]),
    .ev_ovr(ev[7]), .ev_pecerr(ev[8]), .ev_timeout(ev[9]), .ev_alert(ev[10]),
    .irq(irq), .tx_dma_req(dma));

  i2c_irq_regs #(.AW(8), .SMBUS_EN(1'b0)) dut_nosmb (
    .clk, .rst_n, .per_en, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
    .bus_rdata(rdata_ns), .ev_rx_byte(ev[0]), .ev_tx_need(ev[1]), .ev_addr(ev[2]),
    .ev_nack(ev[3]), .ev_stop(ev[4]), .ev_berr(ev[5]), .ev_arlo(ev[6]),
    .ev_ovr(ev[7]), .ev_pecerr(ev[8]), .ev_timeout(ev[9]), .ev_alert(ev[10]),
    .irq(irq_ns), .tx_dma_req(dma_ns));

  // {req[3:0], wr, rd, addr[7:0], wdata[15:0], ev[10:0], expected status[15:0]}
  localparam int NV = 15;
  localparam logic [56:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b0, 8'h00, 16'h0000, 11'h001, 16'h0005},  // R2 byte in
    {4'd2, 1'b0, 1'b1, 8'h24, 16'h0000, 11'h000, 16'h0001},  // R2 read clears
    {4'd3, 1'b0, 1'b0, 8'h00, 16'h0000, 11'h002, 16'h0003},  // R3 need data
    {4'd3, 1'b1, 1'b0, 8'h28, 16'h00A5, 11'h000, 16'h0000},  // R3 data write
    {4'd4, 1'b1, 1'b0, 8'h18, 16'h0001, 11'h000, 16'h0001},  // R4 flush
    {4'd5, 1'b1, 1'b0, 8'h18, 16'h0002, 11'h000, 16'h0001},  // R5 ignored
    {4'd7, 1'b0, 1'b0, 8'h00, 16'h0000, 11'h01C, 16'h0039},  // R7 set
    {4'd7, 1'b1, 1'b0, 8'h1C, 16'h0000, 11'h000, 16'h0039},  // R7 zeros
    {4'd7, 1'b1, 1'b0, 8'h1C, 16'h0010, 11'h000, 16'h0029},  // R7 one bit
    {4'd7, 1'b0, 1'b0, 8'h00, 16'h0000, 11'h7E0, 16'h3F29},  // R7 errors
    {4'd7, 1'b1, 1'b0, 8'h1C, 16'h3F28, 11'h000, 16'h0001},  // R7 clear all
    {4'd8, 1'b1, 1'b0, 8'h1C, 16'h0008, 11'h004, 16'h0009},  // R8 collide
    {4'd7, 1'b1, 1'b0, 8'h1C, 16'h0008, 11'h000, 16'h0001},  // R7 clear
    {4'd8, 1'b1, 1'b0, 8'h28, 16'h0011, 11'h002, 16'h0003},  // R8 tx collide
    {4'd3, 1'b1, 1'b0, 8'h28, 16'h0022, 11'h000, 16'h0000}   // R3
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic [7:0] a, input logic [31:0] wd, input logic [10:0] e);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; ev = e;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; ev = 11'h0; bus_addr = 8'h18;
    #1;
  endtask

  task automatic peek(input logic [7:0] a);
    bus_addr = a; #1;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(8'h18); check("R1", "reset status", rdata, 32'h1);
    peek(8'h00); check("R1", "reset ctrl", rdata, 32'h0);
    check("R1", "reset irq", {31'h0, irq}, 32'h0);
    peek(8'h1C); check("R9", "clear reg read", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][52], VEC[i][51], VEC[i][50:43], {16'h0, VEC[i][42:27]}, VEC[i][26:16]);
      check($sformatf("R%0d", VEC[i][56:53]), $sformatf("vector %0d", i), rdata, {16'h0, VEC[i][15:0]});
    end

    step(1'b1, 1'b0, 8'h00, 32'h40, 11'h0);           // R5 no-stretch on
    step(1'b1, 1'b0, 8'h18, 32'h2, 11'h0);
    check("R5", "sw set txis", rdata, 32'h2);
    step(1'b1, 1'b0, 8'h00, 32'hC0, 11'h0);           // R12
    check("R12", "dma req on", {31'h0, dma}, 32'h1);
    step(1'b1, 1'b0, 8'h00, 32'h01, 11'h0);           // R11
    check("R11", "irq lags one cycle", {31'h0, irq}, 32'h0);
    check("R12", "dma req off", {31'h0, dma}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R11", "irq after lag", {31'h1 & 32'h0, irq}, 32'h1);
    peek(8'h1C); check("R9", "clear reg read later", rdata, 32'h0);

    step(1'b0, 1'b0, 8'h00, 32'h0, 11'h001);
    check("R2", "rx set again", rdata, 32'h6);
    per_en = 1'b0;                                     // R6
    step(1'b0, 1'b0, 8'h00, 32'h0, 11'h003);
    check("R6", "disabled forces", rdata, 32'h1);
    step(1'b1, 1'b0, 8'h18, 32'h2, 11'h001);
    check("R6", "disabled stays", rdata, 32'h1);
    per_en = 1'b1;

    step(1'b0, 1'b0, 8'h00, 32'h0, 11'h700);          // R10
    check("R10", "smbus flags set", rdata & 32'h3800, 32'h3800);
    check("R10", "smbus flags held off", rdata_ns & 32'h3800, 32'h0);
    step(1'b1, 1'b0, 8'h1C, 32'h3800, 11'h0);
    check("R7", "smbus flags cleared", rdata & 32'h3800, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule